// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status and Enable Register

This block holds eight sticky interrupt status flags and eight matching enable flags behind one bus address. A read strobe returns the status flags and, once the access is over, wipes them all. A write strobe loads the enable flags, which cannot be read back. Seven status flags are set by single-cycle event pulses from the controller core. The top flag, command pass-through, is set by a condition built inside the block from decoded bus-state inputs. The interrupt request output is high while any status flag is set together with its enable flag.

A status read can take one or more cycles. The status value stays frozen for the whole strobe, so software never sees a half-updated byte. An event that arrives while the strobe is high is caught in a per-bit pending latch. The clear takes effect on the first clock edge after the strobe drops, and at that edge the pending latch and any event arriving in that same cycle are merged into the freshly cleared status. No event is lost across a read.

Top module: `irq_stat_mask`

## Requirements
- R1: After reset, rd_data reads 0, irq is 0 and every enable flag is 0. An event therefore raises no request until software writes an enable.
- R2: Status bit positions are: 7 command pass-through, 6 address pass-through, 5 device trigger, 4 end received, 3 device clear, 2 error, 1 data-out ready, 0 data-in ready. A pulse on evt_in[k] (k from 0 to 6) in a cycle without a read strobe sets rd_data[k] from the next cycle on. The bit stays set until a read clears it.
- R3: Status bits are set by their events whatever the value of the matching enable bit.
- R4: rd_data always shows the status register. A read is a run of one or more cycles with rd_stb high. At the first clock edge with rd_stb low after such a run, all status bits are cleared, except those kept by R5 and R6.
- R5: While rd_stb is high, rd_data does not change. An event that pulses during the strobe is held back and appears in rd_data one cycle after the first low cycle of rd_stb.
- R6: An event that pulses in the first cycle with rd_stb low after a read, which is the cycle whose edge applies the clear, is still set after the clear.
- R7: A write (wr_stb high for one cycle) loads wr_data into the enable register at that clock edge. Writes never change the status bits, and reads never change the enable bits.
- R8: irq is a registered level. After each clock edge it equals the OR over all bits of (status AND enable), as both registers stand after that edge.
- R9: Status bit 7 is set when pt_enable and data_accepted are both high and one of two cases holds. Case one: cmd_self_handled is low while cmd_univ is high, or while cmd_addr is high together with is_talker or is_listener. Case two: prim_undef and sec_follows are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rd_stb | input | 1 | Status read strobe, held high for the length of the access |
| rd_data | output | WIDTH | Status register contents |
| wr_stb | input | 1 | Enable register write strobe |
| wr_data | input | WIDTH | Data loaded into the enable register |
| evt_in | input | WIDTH-1 | Single-cycle event pulses for status bits WIDTH-2 down to 0 |
| cmd_univ | input | 1 | Universal command on the bus |
| cmd_addr | input | 1 | Addressed command on the bus |
| is_talker | input | 1 | Device is addressed to talk |
| is_listener | input | 1 | Device is addressed to listen |
| cmd_self_handled | input | 1 | Command is recognised and executed by the core |
| prim_undef | input | 1 | Previous primary command was undefined |
| sec_follows | input | 1 | Current byte is a secondary command |
| data_accepted | input | 1 | Bus data-accepted state active |
| pt_enable | input | 1 | Command pass-through enabled |
| irq | output | 1 | Active-high interrupt request level |

## Verification
The bench builds the block with its default WIDTH of 8. This keeps the full space small enough to sweep. Every one of the 256 enable values is written against several status patterns. All 512 combinations of the nine pass-through inputs are applied and checked against an independently written set equation. Read strobes of one to three cycles are combined with an event placed in every cycle from the first strobe cycle to the cycle after the clear, for every event bit, on top of a preloaded status byte. This covers each position where an event could collide with the clear.

// File: rtl/irqsm_pkg.sv
package irqsm_pkg;

  // decoded bus state feeding the pass-through condition
  typedef struct packed {
    logic univ;
    logic addr;
    logic talk;
    logic lstn;
    logic known;
    logic undef;
    logic sec;
    logic accept;
    logic en;
  } cmd_state_t;

  // pass-through set condition, kept here so it reads as one equation
  function automatic logic pt_condition(input cmd_state_t s);
    logic unhandled;
    logic undef_pair;
    unhandled  = (s.univ | (s.addr & (s.talk | s.lstn))) & ~s.known;
    undef_pair = s.undef & s.sec;
    return s.en & s.accept & (unhandled | undef_pair);
  endfunction

endpackage

// File: rtl/irqsm_pt_decode.sv
module irqsm_pt_decode
  import irqsm_pkg::*;
(
  input  cmd_state_t st,
  output logic       pt_hit
);

  always_comb pt_hit = pt_condition(st);

endmodule

// File: rtl/irqsm_rd_track.sv
module irqsm_rd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  output logic rd_q,
  output logic rd_end
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_stb;
  end

  // first low cycle after a strobe run: its edge applies the clear
  assign rd_end = rd_q & ~rd_stb;

endmodule

// File: rtl/irqsm_status_bit.sv
module irqsm_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_stb,
  input  logic rd_end,
  output logic stat_q,
  output logic stat_d,
  output logic pend_q
);

  logic pend_d;

  always_comb begin
    stat_d = stat_q | evt;
    pend_d = 1'b0;
    if (rd_end) begin
      stat_d = pend_q | evt;
    end else if (rd_stb) begin
      stat_d = stat_q;
      pend_d = pend_q | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/irqsm_enable_irq.sv
module irqsm_enable_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] stat_d,
  output logic [WIDTH-1:0] en_q,
  output logic             irq
);

  logic [WIDTH-1:0] en_d;

  function automatic logic any_armed(input logic [WIDTH-1:0] s,
                                     input logic [WIDTH-1:0] e);
    return |(s & e);
  endfunction

  always_comb en_d = wr_stb ? wr_data : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= en_d;
      irq  <= any_armed(stat_d, en_d);
    end
  end

endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask
  import irqsm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-2:0] evt_in,
  input  logic             cmd_univ,
  input  logic             cmd_addr,
  input  logic             is_talker,
  input  logic             is_listener,
  input  logic             cmd_self_handled,
  input  logic             prim_undef,
  input  logic             sec_follows,
  input  logic             data_accepted,
  input  logic             pt_enable,
  output logic             irq
);

  localparam int PT_BIT = WIDTH - 1;

  cmd_state_t       cmd_st;
  logic             pt_hit;
  logic             rd_q;
  logic             rd_end;
  logic [WIDTH-1:0] evt_all;
  logic [WIDTH-1:0] stat_all;
  logic [WIDTH-1:0] stat_next;
  logic [WIDTH-1:0] pend_all;
  logic [WIDTH-1:0] en_q;

  assign cmd_st = '{univ: cmd_univ, addr: cmd_addr, talk: is_talker,
                    lstn: is_listener, known: cmd_self_handled,
                    undef: prim_undef, sec: sec_follows,
                    accept: data_accepted, en: pt_enable};

  irqsm_pt_decode u_pt (
    .st     (cmd_st),
    .pt_hit (pt_hit)
  );

  assign evt_all = {pt_hit, evt_in};

  irqsm_rd_track u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .rd_q   (rd_q),
    .rd_end (rd_end)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    irqsm_status_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_all[b]),
      .rd_stb (rd_stb),
      .rd_end (rd_end),
      .stat_q (stat_all[b]),
      .stat_d (stat_next[b]),
      .pend_q (pend_all[b])
    );
  end

  irqsm_enable_irq #(.WIDTH(WIDTH)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .stat_d  (stat_next),
    .en_q    (en_q),
    .irq     (irq)
  );

  assign rd_data = stat_all;

  // the pass-through flag must land on the top bit of the byte
  initial begin
    if (PT_BIT != WIDTH - 1) $error("pass-through bit misplaced");
  end

endmodule

// File: rtl/irq_stat_mask_chk.sv
module irq_stat_mask_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_stb,
  input logic             rd_q,
  input logic             wr_stb,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic             irq,
  input logic [WIDTH-1:0] en_q,
  input logic [WIDTH-1:0] evt_all,
  input logic [WIDTH-1:0] pend_all,
  input logic             pt_enable,
  input logic             data_accepted,
  input logic             prim_undef,
  input logic             sec_follows
);

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !rd_stb && evt_all == '0 && pend_all == '0) |=> rd_data == '0); // R4

  AST_STAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (!rd_stb || $stable(rd_data))); // R5

  AST_PEND_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((pend_all & $past(evt_all)) == $past(evt_all))); // R5

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((rd_data & $past(evt_all)) == $past(evt_all))); // R6

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> en_q == $past(wr_data)); // R7

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(en_q)); // R7

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(rd_data & en_q)); // R8

  AST_PT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_enable && data_accepted && prim_undef && sec_follows && !rd_stb)
      |=> rd_data[WIDTH-1]); // R9

endmodule

bind irq_stat_mask irq_stat_mask_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_stb        (rd_stb),
  .rd_q          (rd_q),
  .wr_stb        (wr_stb),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .irq           (irq),
  .en_q          (en_q),
  .evt_all       (evt_all),
  .pend_all      (pend_all),
  .pt_enable     (pt_enable),
  .data_accepted (data_accepted),
  .prim_undef    (prim_undef),
  .sec_follows   (sec_follows)
);

// File: tb/test_irq_stat_mask.sv
module test_irq_stat_mask;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_stb = 1'b0;
  logic [W-1:0] rd_data;
  logic         wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-2:0] evt_in = '0;
  logic cmd_univ = 0, cmd_addr = 0, is_talker = 0, is_listener = 0;
  logic cmd_self_handled = 0, prim_undef = 0, sec_follows = 0;
  logic data_accepted = 0, pt_enable = 0;
  logic         irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  irq_stat_mask #(.WIDTH(W)) i_irq_stat_mask (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_data(wr_data), .evt_in(evt_in),
    .cmd_univ(cmd_univ), .cmd_addr(cmd_addr), .is_talker(is_talker),
    .is_listener(is_listener), .cmd_self_handled(cmd_self_handled),
    .prim_undef(prim_undef), .sec_follows(sec_follows),
    .data_accepted(data_accepted), .pt_enable(pt_enable), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic read_clear();
    rd_stb = 1'b1; step();
    rd_stb = 1'b0; step();
  endtask

  task automatic pulse(input logic [W-2:0] v);
    evt_in = v; step();
    evt_in = '0;
  endtask

  task automatic set_pt();
    pt_enable = 1; data_accepted = 1; prim_undef = 1; sec_follows = 1;
    step();
    pt_enable = 0; data_accepted = 0; prim_undef = 0; sec_follows = 0;
  endtask

  task automatic write_en(input logic [W-1:0] e);
    wr_stb = 1'b1; wr_data = e; step();
    wr_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] pats [5];
    pats = '{8'h00, 8'h01, 8'h40, 8'h80, 8'h5A};
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 status", rd_data, 0);
    chk("R1 irq", irq, 0);
    // R3: events set status with all enables at reset zero; R1 no request
    pulse(7'h7F);
    chk("R3 set with enables off", rd_data, 8'h7F);
    chk("R1 enables zero", irq, 0);
    read_clear();
    chk("R4 cleared", rd_data, 0);

    // R2 each event bit to its own position
    for (int k = 0; k < W - 1; k++) begin
      pulse(7'(1 << k));
      chk("R2 bit position", rd_data, 1 << k);
      pulse(7'(1 << k));
      chk("R2 sticky", rd_data, 1 << k);
      read_clear();
    end

    // R4 read returns status, clear after strobe drops
    pulse(7'h55);
    rd_stb = 1'b1; step();
    chk("R4 read value", rd_data, 8'h55);
    rd_stb = 1'b0;
    chk("R4 value in end cycle", rd_data, 8'h55);
    step();
    chk("R4 cleared after read", rd_data, 0);

    // R5/R6 event against every position of the read window
    for (int len = 1; len <= 3; len++) begin
      for (int off = 0; off <= len + 1; off++) begin
        for (int k = 0; k < W - 1; k++) begin
          logic [W-1:0] bitv;
          logic [W-1:0] pre;
          bitv = W'(1 << k);
          pre  = 8'h7F ^ bitv;
          pulse(pre[W-2:0]);
          for (int c = 0; c <= len + 1; c++) begin
            rd_stb = (c < len);
            evt_in = (c == off) ? bitv[W-2:0] : '0;
            if (c == len) chk("R5 frozen during read", rd_data, pre);
            step();
          end
          evt_in = '0;
          chk(off == len ? "R6 event at clear kept" : "R5 deferred event kept",
              rd_data, bitv);
          read_clear();
        end
      end
    end

    // R7/R8 all enable values against several status patterns
    foreach (pats[p]) begin
      read_clear();
      if (pats[p][7]) set_pt();
      pulse(pats[p][6:0]);
      for (int e = 0; e < 256; e++) begin
        write_en(W'(e));
        chk("R8 irq level", irq, ((pats[p] & W'(e)) != 0) ? 1 : 0);
        chk("R7 write leaves status", rd_data, pats[p]);
      end
    end

    // R7 read leaves enable; R8 irq follows clear
    read_clear();
    write_en(8'h01);
    pulse(7'h01);
    chk("R8 irq raised", irq, 1);
    read_clear();
    chk("R8 irq drops on clear", irq, 0);
    pulse(7'h01);
    chk("R7 enable kept over read", irq, 1);
    read_clear();
    write_en(8'h00);

    // R9 all pass-through input combinations
    for (int i = 0; i < 512; i++) begin
      logic exp_pt;
      logic [8:0] v;
      v = 9'(i);
      read_clear();
      {pt_enable, data_accepted, cmd_univ, cmd_addr, is_talker, is_listener,
       cmd_self_handled, prim_undef, sec_follows} = v;
      exp_pt = v[8] && v[7] &&
               ((!v[2] && (v[6] || (v[5] && (v[4] || v[3])))) || (v[1] && v[0]));
      step();
      {pt_enable, data_accepted, cmd_univ, cmd_addr, is_talker, is_listener,
       cmd_self_handled, prim_undef, sec_follows} = '0;
      chk("R9 pass-through set", rd_data, exp_pt ? 8'h80 : 8'h00);
    end

    finish_run();
  end

endmodule